// File: doc/BRIEF.md
# EEPROM Page-Write Engine

This block is a clocked stand-in for the write path of a byte-wide nonvolatile memory. A host issues decoded write events, each an address and a data byte. The first write opens a page operation. Later writes to the same page are gathered in a page buffer, as long as each one arrives within a fixed load window after the previous accepted write. When the window passes with no new load, a self-timed programming phase starts. At its end, the buffered bytes are committed to the storage array in a single cycle.

While programming runs, the read path reports progress in the data it returns. Bit 6 inverts on every read. On the byte written last, bit 7 reads as the complement of the written value. When programming ends, reads return the true array contents again.

The window and the programming time are parameters counted in clock cycles. The defaults are 5000 and 250000 cycles, which match a 50 MHz clock. The array has 2^ADDR_W bytes. The upper ADDR_W-OFF_W address bits select the page and the lower OFF_W bits select a byte within it. Setting ADDR_W=17 and OFF_W=8 gives 131072 bytes in 256-byte pages.

Top module: `eeprom_page_wr`

## Requirements
- R1: After reset, busy_o, page_err_o and rvalid_o are 0, and every array byte reads as 0x00.
- R2: A read request (rd_i high at a clock edge) gives rvalid_o=1 in the next cycle. Outside programming, rdata_o then equals the array byte at addr_i.
- R3: A load is accepted if it is the first write of an operation, or if it arrives at most WIN_CYC cycles after the previous accepted load. A load at exactly WIN_CYC cycles is still accepted. Programming begins when WIN_CYC cycles pass after the last accepted load with no further accepted load. busy_o rises exactly WIN_CYC cycles after that load.
- R4: During a page operation, a write whose page bits (addr_i[ADDR_W-1:OFF_W]) differ from those of the first load is discarded. It causes page_err_o=1 for the one following cycle, and it does not restart the load window.
- R5: busy_o stays high for exactly PROG_CYC cycles. After it falls, the array holds the new data.
- R6: Only offsets loaded in the current operation change, and no erase is needed. The other bytes of the page keep their old values. When an offset is loaded twice, the later data wins.
- R7: Writes presented while busy_o is high are ignored and raise no page_err_o.
- R8: A read made while busy_o is high returns the old array byte in bits 5..0. For the last accepted load address, bit 7 reads as the inverse of that load's bit 7. For any other address, bit 7 is the old array bit.
- R9: During programming, bit 6 of the first read is 0, and each later read inverts it.
- R10: Reads made during the load phase, before programming starts, return the old array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write event (byte load) for this cycle |
| rd_i | input | 1 | Read request for this cycle |
| addr_i | input | ADDR_W | Byte address for a write or a read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, with status bits substituted while busy |
| rvalid_o | output | 1 | rdata_o is valid, one cycle after rd_i |
| busy_o | output | 1 | Programming phase in progress |
| page_err_o | output | 1 | One-cycle pulse after a page-mismatched load |

## Verification
On every cycle, the assertions check the following:
- the exact gap between the last accepted load and the rise of busy_o;
- the length of each busy period;
- that no load is accepted while busy;
- the origin of every page_err_o pulse;
- the read-valid latency;
- the alternation of bit 6 across reads made while busy.

Only the bench scenarios can show the remaining behaviour. This covers data landing in the right array bytes with untouched neighbours, the last load winning for a repeated offset, the complemented bit 7 on the last-written address, and reads during the load phase returning old data. The bench checks these against an arithmetic model by sweeping every address of a small configuration after each operation.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } pw_state_e;
endpackage

// File: rtl/eeprom_pw_ctrl.sv
module eeprom_pw_ctrl
  import eeprom_pw_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int WIN_CYC  = 5000,
  parameter int PROG_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              accept_o,
  output logic              commit_o,
  output logic              busy_o,
  output logic              page_err_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  pw_state_e         state_q;
  logic [WIN_W-1:0]  win_q;
  logic [PROG_W-1:0] prog_q;
  logic [PAGE_W-1:0] page_q;
  logic              mismatch;

  assign accept_o = wr_i && ((state_q == ST_IDLE) ||
                             (state_q == ST_LOAD && page_i == page_q));
  assign mismatch = wr_i && state_q == ST_LOAD && page_i != page_q;
  assign commit_o = state_q == ST_PROG && prog_q == PROG_W'(PROG_CYC - 1);
  assign busy_o   = state_q == ST_PROG;
  assign page_o   = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      win_q      <= '0;
      prog_q     <= '0;
      page_q     <= '0;
      page_err_o <= 1'b0;
    end else begin
      page_err_o <= mismatch;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          page_q  <= page_i;
          win_q   <= '0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          // a load on the final window cycle still wins over the timeout
          if (accept_o) win_q <= '0;
          else if (win_q == WIN_W'(WIN_CYC - 1)) begin
            state_q <= ST_PROG;
            prog_q  <= '0;
          end else win_q <= win_q + 1'b1;
        end
        ST_PROG: begin
          if (commit_o) state_q <= ST_IDLE;
          else prog_q <= prog_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_pw_pagebuf.sv
module eeprom_pw_pagebuf #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  localparam int NB    = 1 << OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [OFF_W-1:0]             off_i,
  input  logic [DATA_W-1:0]            data_i,
  input  logic                         clear_i,
  output logic [NB-1:0][DATA_W-1:0]    data_o,
  output logic [NB-1:0]                mask_o
);
  for (genvar g = 0; g < NB; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g] <= '0;
        mask_o[g] <= 1'b0;
      end else if (clear_i) begin
        mask_o[g] <= 1'b0;
      end else if (load_i && off_i == OFF_W'(g)) begin
        data_o[g] <= data_i;
        mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_pw_array.sv
module eeprom_pw_array #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int NB     = 1 << OFF_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [PAGE_W-1:0]         page_i,
  input  logic [NB-1:0][DATA_W-1:0] buf_data_i,
  input  logic [NB-1:0]             buf_mask_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  input  logic                      busy_i,
  input  logic [ADDR_W-1:0]         last_addr_i,
  input  logic [DATA_W-1:0]         last_data_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o
);
  localparam int DP_BIT = DATA_W - 1;
  localparam int TG_BIT = DATA_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              tog_q;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_i) begin
      for (int j = 0; j < NB; j++)
        if (buf_mask_i[j]) mem[{page_i, OFF_W'(j)}] <= buf_data_i[j];
    end
  end

  always_comb begin
    word = mem[raddr_i];
    if (busy_i) begin
      word[TG_BIT] = tog_q;
      if (raddr_i == last_addr_i) word[DP_BIT] = ~last_data_i[DP_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q    <= 1'b0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= word;
      if (!busy_i) tog_q <= 1'b0;
      else if (rd_i) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/eeprom_page_wr.sv
module eeprom_page_wr #(
  parameter int ADDR_W   = 11,
  parameter int OFF_W    = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_CYC  = 5000,
  parameter int PROG_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  output logic              page_err_o
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int NB     = 1 << OFF_W;

  logic                      ld_accept;
  logic                      commit;
  logic [PAGE_W-1:0]         cur_page;
  logic [NB-1:0][DATA_W-1:0] buf_data;
  logic [NB-1:0]             buf_mask;
  logic [ADDR_W-1:0]         last_addr_q;
  logic [DATA_W-1:0]         last_data_q;

  eeprom_pw_ctrl #(.PAGE_W(PAGE_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk_i, .rst_ni, .wr_i,
    .page_i     (addr_i[ADDR_W-1:OFF_W]),
    .accept_o   (ld_accept),
    .commit_o   (commit),
    .busy_o,
    .page_err_o,
    .page_o     (cur_page)
  );

  eeprom_pw_pagebuf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i  (ld_accept),
    .off_i   (addr_i[OFF_W-1:0]),
    .data_i  (wdata_i),
    .clear_i (commit),
    .data_o  (buf_data),
    .mask_o  (buf_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_data_q <= '0;
    end else if (ld_accept) begin
      last_addr_q <= addr_i;
      last_data_q <= wdata_i;
    end
  end

  eeprom_pw_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .commit_i    (commit),
    .page_i      (cur_page),
    .buf_data_i  (buf_data),
    .buf_mask_i  (buf_mask),
    .rd_i,
    .raddr_i     (addr_i),
    .busy_i      (busy_o),
    .last_addr_i (last_addr_q),
    .last_data_i (last_data_q),
    .rdata_o,
    .rvalid_o
  );
endmodule

// File: rtl/eeprom_page_wr_chk.sv
module eeprom_page_wr_chk #(
  parameter int WIN_CYC  = 5000,
  parameter int PROG_CYC = 250000,
  parameter int DATA_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              busy_o,
  input logic              page_err_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ld_accept
);
  int   gap_q;
  int   run_q;
  logic rd_busy_q;
  logic prev_ok_q;
  logic prev_b6_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= WIN_CYC + 1;
      run_q     <= 0;
      rd_busy_q <= 1'b0;
      prev_ok_q <= 1'b0;
      prev_b6_q <= 1'b0;
    end else begin
      if (ld_accept) gap_q <= 0;
      else if (gap_q <= WIN_CYC) gap_q <= gap_q + 1;
      run_q     <= busy_o ? run_q + 1 : 0;
      rd_busy_q <= rd_i && busy_o;
      if (rd_busy_q) begin
        prev_ok_q <= 1'b1;
        prev_b6_q <= rdata_o[DATA_W-2];
      end else if (!busy_o) prev_ok_q <= 1'b0;
    end
  end

  // R3
  a_r3_window_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> gap_q == WIN_CYC);
  // R5
  a_r5_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= PROG_CYC);
  a_r5_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == PROG_CYC);
  // R7
  a_r7_no_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ld_accept);
  // R4
  a_r4_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_err_o |-> $past(wr_i) && !$past(busy_o));
  // R2
  a_r2_rvalid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  a_r2_rvalid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  // R9
  a_r9_toggle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_q && !prev_ok_q |-> !rdata_o[DATA_W-2]);
  a_r9_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_q && prev_ok_q |-> rdata_o[DATA_W-2] != prev_b6_q);
endmodule

bind eeprom_page_wr eeprom_page_wr_chk #(
  .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC), .DATA_W(DATA_W)
) u_chk (
  .clk_i, .rst_ni, .wr_i, .rd_i, .busy_o, .page_err_o, .rvalid_o, .rdata_o,
  .ld_accept (ld_accept)
);

// File: tb/eeprom_page_wr_test.sv
module eeprom_page_wr_test;
  localparam int AW = 8, OW = 4, W = 6, P = 20;
  localparam int DEPTH = 1 << AW, NB = 1 << OW, NP = 1 << (AW - OW);

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rvalid, busy, perr;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m [DEPTH];
  logic [7:0] pb [NB];
  bit pm [NB];
  int cur_pg;
  logic [AW-1:0] last_a;
  logic [7:0] last_d;

  always #10 clk = ~clk;

  eeprom_page_wr #(.ADDR_W(AW), .OFF_W(OW), .DATA_W(8), .WIN_CYC(W), .PROG_CYC(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy), .page_err_o(perr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // good load: tracked in the page model
  task automatic ld(input int a, input int d);
    addr = AW'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    pb[a % NB] = 8'(d); pm[a % NB] = 1'b1;
    cur_pg = a / NB; last_a = AW'(a); last_d = 8'(d);
  endtask

  // write expected to be dropped
  task automatic ld_drop(input int a, input int d);
    addr = AW'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] d);
    addr = AW'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(rvalid === 1'b1, "R2 rvalid", int'(rvalid), 1);
    d = rdata;
  endtask

  task automatic commit_model();
    for (int o = 0; o < NB; o++) begin
      if (pm[o]) m[cur_pg * NB + o] = pb[o];
      pm[o] = 1'b0;
    end
  endtask

  task automatic sweep(input string req);
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      rd_byte(a, d);
      chk(d === m[a], req, int'(d), int'(m[a]));
    end
  endtask

  // called "el" cycles after the last accepted load
  task automatic run_prog(input int el);
    logic [7:0] d, e;
    bit tog;
    wait_cyc(W - 1 - el);
    chk(busy === 1'b0, "R3 not yet busy", int'(busy), 0);
    wait_cyc(1);
    chk(busy === 1'b1, "R3 busy after window", int'(busy), 1);
    tog = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int a;
      a = (i % 2 == 0) ? int'(last_a) : int'(last_a ^ 1);
      rd_byte(a, d);
      e = m[a];
      e[6] = tog;
      if (a == int'(last_a)) e[7] = ~last_d[7];
      chk(d === e, (a == int'(last_a)) ? "R8 R9 status last" : "R8 R9 status other",
          int'(d), int'(e));
      tog = ~tog;
    end
    ld_drop(int'(last_a ^ 2), 8'hEE);
    chk(perr === 1'b0, "R7 no error while busy", int'(perr), 0);
    wait_cyc(P - 1 - 5);
    chk(busy === 1'b1, "R5 busy held", int'(busy), 1);
    wait_cyc(1);
    chk(busy === 1'b0, "R5 busy ends", int'(busy), 0);
    commit_model();
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 200000 && !done; wd++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) m[a] = 8'h00;
    for (int o = 0; o < NB; o++) begin pm[o] = 1'b0; pb[o] = 8'h00; end
    cur_pg = 0; last_a = '0; last_d = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(perr === 1'b0, "R1 err", int'(perr), 0);
    chk(rvalid === 1'b0, "R1 rvalid", int'(rvalid), 0);
    sweep("R1 array zero");

    // full page, gaps up to the window boundary
    for (int o = 0; o < NB; o++) begin
      ld(3 * NB + o, (o * 37 + 11) & 8'hFF);
      if (o < NB - 1) wait_cyc(o % W);
    end
    run_prog(0);
    sweep("R5 R6 full page");

    // mismatch, read in load phase, repeat offset
    ld(3 * NB + 2, 8'h5A);
    ld_drop(9 * NB + 2, 8'h11);
    chk(perr === 1'b1, "R4 err pulse", int'(perr), 1);
    wait_cyc(1);
    chk(perr === 1'b0, "R4 err one cycle", int'(perr), 0);
    rd_byte(3 * NB + 2, d);
    chk(d === m[3 * NB + 2], "R10 read during load", int'(d), int'(m[3 * NB + 2]));
    ld(3 * NB + 2, 8'hC3);
    ld(3 * NB + 9, 8'h80);
    ld_drop(0 * NB + 9, 8'h22);
    chk(perr === 1'b1, "R4 err pulse 2", int'(perr), 1);
    run_prog(1);
    sweep("R4 R6 partial page");

    // exact boundary load, then a late write during programming
    ld(7 * NB + 4, 8'h3C);
    wait_cyc(W - 1);
    chk(busy === 1'b0, "R3 boundary idle", int'(busy), 0);
    ld(7 * NB + 5, 8'h77);
    wait_cyc(W);
    chk(busy === 1'b1, "R3 busy from boundary load", int'(busy), 1);
    ld_drop(7 * NB + 6, 8'h99);
    chk(perr === 1'b0, "R7 late write no error", int'(perr), 0);
    wait_cyc(P - 2);
    chk(busy === 1'b1, "R5 busy held 2", int'(busy), 1);
    wait_cyc(1);
    chk(busy === 1'b0, "R5 busy ends 2", int'(busy), 0);
    commit_model();
    sweep("R3 R7 boundary");

    // every page, varied masks
    for (int p = 0; p < NP; p++) begin
      int k;
      k = 0;
      for (int o = 0; o < NB; o++) begin
        if ((o + p) % 3 == 0) begin
          if (k > 0) wait_cyc(k % W);
          ld(p * NB + o, ((p * 16 + o) ^ 8'hA5) & 8'hFF);
          k++;
        end
      end
      run_prog(0);
    end
    sweep("R6 all pages");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule